// File: doc/BRIEF.md
# Ring Buffer DMA Pointer Tracker

This block keeps the control and status state of one ring-buffer DMA channel placed between a serial port and memory. The ring is a power-of-two region in memory. The block holds a write pointer and a read pointer into it. Each pointer is a ring offset plus a wrap bit that flips every time the pointer passes the end of the ring, so a full ring and an empty ring can be told apart. From the two pointers it derives the number of bytes waiting in the ring and the free space left. It also raises a sticky threshold flag that drives an interrupt line.

A parameter sets the direction of the channel. On a transmit channel, software fills the ring by writing the write pointer, and the byte mover drains it by advancing the read pointer. On a receive channel the roles swap: the byte mover advances the write pointer and software writes the read pointer. The byte mover uses a single-cycle advance port. The block clamps each advance to what is currently available and returns the ring offset the mover should use next. Software reaches enable, stop, flush, warm reset, ring length, threshold, both pointers and both levels through a small word-addressed register map.

Top module: `ring_ptr_tracker`

## Requirements
- R1: After reset both pointers, enable, stop, interrupt enables and flags read 0, the length reads 2^PTR_W, the threshold reads all ones over PTR_W+1 bits, and irq is low.
- R2: A pointer value has its ring offset in bits [PTR_W-1:0] and its wrap bit in bit PTR_W. An advance by n starting at offset o with ring length L gives offset (o+n) mod L and an inverted wrap bit when o+n >= L. Otherwise it gives offset o+n and keeps the wrap bit.
- R3: Valid size (read at 0x3C) is woff-roff when the wrap bits are equal and L-roff+woff when they differ, where each offset is the pointer ANDed with L-1. Left size (read at 0x40) is L minus the valid size.
- R4: With IS_RX=0, software writes the write pointer (0x2C), the advance port moves the read pointer, and adv_avail equals the valid size. With IS_RX=1, software writes the read pointer (0x30), the advance port moves the write pointer, and adv_avail equals the left size. A software write to the pointer owned by the advance port leaves it unchanged. hw_offset is the ring offset of that pointer.
- R5: An advance request larger than adv_avail moves the pointer by adv_avail only. Otherwise it moves the pointer by the requested count. The change takes effect at the next clock edge.
- R6: While enable (0x08 bit 0) is 0 or stop (0x10 bit 0) is 1, advance requests leave the pointers unchanged.
- R7: Writing 1 to bit 0 of 0x14 sets the read pointer, wrap bit included, equal to the write pointer at the next edge, and drops any advance in that cycle. The register reads 0.
- R8: Writing 1 to bit 0 of 0x0C clears both pointers, including their wrap bits, and the flags. It keeps length (0x24), threshold (0x28), enable and interrupt enables. The register reads 0.
- R9: The flag register (0x00) is sticky and is updated one edge after its condition. On RX, bits 0 and 1 are set while valid size >= threshold. On TX, bit 0 is set while left size >= threshold.
- R10: On RX, writing a 1 to flag bit 0 or bit 1 clears that bit. On TX, writing 0 to bit 0 clears it and writing 1 has no effect. A condition that still holds sets the flag again at the same edge.
- R11: irq is the OR of flag bits ANDed with the interrupt enable bits (0x04). RX keeps enable bits 0 and 1. TX keeps only bit 0, and bit 1 reads 0.
- R12: The other register addresses hold their values as written: length at 0x24 and threshold at 0x28, each PTR_W+1 bits. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| adv_valid | input | 1 | Advance request from the byte mover |
| adv_count | input | PTR_W+1 | Requested advance in bytes |
| adv_avail | output | PTR_W+1 | Bytes the byte mover may move now |
| hw_offset | output | PTR_W | Ring offset of the pointer owned by the byte mover |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two copies with PTR_W=5: one transmit channel and one receive channel. The wrap bit therefore sits at bit 5 and every ring fits in a few dozen bytes. Ring lengths of 8, 16 and 32 are swept, the last one using the whole offset field as mask. Over each sweep the bench takes both pointers around the ring several times with requests above and below the available count, and moves the threshold through every value from 0 to the length. Wrap flips, full-versus-empty cases, clamping and both threshold comparisons are all checked against arithmetic models.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
   localparam logic [7:0] ADR_FLAG  = 8'h00;
   localparam logic [7:0] ADR_IEN   = 8'h04;
   localparam logic [7:0] ADR_EN    = 8'h08;
   localparam logic [7:0] ADR_WRST  = 8'h0C;
   localparam logic [7:0] ADR_STOP  = 8'h10;
   localparam logic [7:0] ADR_FLUSH = 8'h14;
   localparam logic [7:0] ADR_LEN   = 8'h24;
   localparam logic [7:0] ADR_THRE  = 8'h28;
   localparam logic [7:0] ADR_WPTR  = 8'h2C;
   localparam logic [7:0] ADR_RPTR  = 8'h30;
   localparam logic [7:0] ADR_VALID = 8'h3C;
   localparam logic [7:0] ADR_LEFT  = 8'h40;
endpackage

// File: rtl/ring_ptr_step.sv
module ring_ptr_step #(
   parameter int PTR_W = 16
) (
   input  logic [PTR_W:0] ptr_in,
   input  logic [PTR_W:0] step,
   input  logic [PTR_W:0] ring_len,
   output logic [PTR_W:0] ptr_out
);
   localparam int SUM_W = PTR_W + 2;

   logic [PTR_W:0]   mask;
   logic [PTR_W-1:0] off;
   logic [SUM_W-1:0] sum;

   always_comb begin
      mask = ring_len - 1'b1;
      off  = ptr_in[PTR_W-1:0] & mask[PTR_W-1:0];
      sum  = SUM_W'(off) + SUM_W'(step);
      if (sum >= SUM_W'(ring_len))
         ptr_out = {~ptr_in[PTR_W], sum[PTR_W-1:0] & mask[PTR_W-1:0]};
      else
         ptr_out = {ptr_in[PTR_W], sum[PTR_W-1:0]};
   end
endmodule

// File: rtl/ring_ptr_level.sv
module ring_ptr_level #(
   parameter int PTR_W = 16
) (
   input  logic [PTR_W:0] wptr,
   input  logic [PTR_W:0] rptr,
   input  logic [PTR_W:0] ring_len,
   output logic [PTR_W:0] valid_cnt,
   output logic [PTR_W:0] left_cnt
);
   logic [PTR_W:0] mask;
   logic [PTR_W:0] woff;
   logic [PTR_W:0] roff;

   always_comb begin
      mask = ring_len - 1'b1;
      woff = {1'b0, wptr[PTR_W-1:0]} & mask;
      roff = {1'b0, rptr[PTR_W-1:0]} & mask;
      if (wptr[PTR_W] == rptr[PTR_W])
         valid_cnt = woff - roff;
      else
         valid_cnt = ring_len - roff + woff;
      left_cnt = ring_len - valid_cnt;
   end
endmodule

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker
   import ring_ptr_pkg::*;
#(
   parameter int PTR_W = 16,
   parameter bit IS_RX = 1'b0,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic             adv_valid,
   input  logic [PTR_W:0]   adv_count,
   output logic [PTR_W:0]   adv_avail,
   output logic [PTR_W-1:0] hw_offset,
   output logic             irq
);
   localparam logic [PTR_W:0] LEN_RST   = {1'b1, {PTR_W{1'b0}}};
   localparam logic [PTR_W:0] THRE_RST  = '1;
   localparam logic [1:0]     FLAG_MASK = IS_RX ? 2'b11 : 2'b01;

   if (PTR_W < 2 || PTR_W > 30) begin : g_bad_ptr_w
      $error("ring_ptr_tracker: PTR_W must lie in 2..30");
   end
   if (DW < PTR_W + 1) begin : g_bad_dw
      $error("ring_ptr_tracker: DW too narrow for a pointer");
   end

   logic           en_q, stop_q;
   logic [1:0]     ien_q, flag_q, clr;
   logic [PTR_W:0] len_q, thre_q, wptr_q, rptr_q;
   logic [PTR_W:0] valid_cnt, left_cnt, hw_ptr, hw_nxt, take;
   logic           cond, blocked;

   logic wr_flag, wr_ien, wr_en, wr_stop, wr_len, wr_thre, wr_wptr, wr_rptr;
   logic rst_pulse, flush_pulse;

   assign wr_flag     = reg_wr && reg_addr == ADR_FLAG;
   assign wr_ien      = reg_wr && reg_addr == ADR_IEN;
   assign wr_en       = reg_wr && reg_addr == ADR_EN;
   assign wr_stop     = reg_wr && reg_addr == ADR_STOP;
   assign wr_len      = reg_wr && reg_addr == ADR_LEN;
   assign wr_thre     = reg_wr && reg_addr == ADR_THRE;
   assign wr_wptr     = reg_wr && reg_addr == ADR_WPTR;
   assign wr_rptr     = reg_wr && reg_addr == ADR_RPTR;
   assign rst_pulse   = reg_wr && reg_addr == ADR_WRST && reg_wdata[0];
   assign flush_pulse = reg_wr && reg_addr == ADR_FLUSH && reg_wdata[0];
   assign blocked     = !en_q || stop_q;

   ring_ptr_level #(.PTR_W(PTR_W)) u_level (
      .wptr      (wptr_q),
      .rptr      (rptr_q),
      .ring_len  (len_q),
      .valid_cnt (valid_cnt),
      .left_cnt  (left_cnt)
   );

   if (IS_RX) begin : g_rx
      assign hw_ptr    = wptr_q;
      assign adv_avail = left_cnt;
      assign cond      = valid_cnt >= thre_q;
   end else begin : g_tx
      assign hw_ptr    = rptr_q;
      assign adv_avail = valid_cnt;
      assign cond      = left_cnt >= thre_q;
   end

   always_comb begin
      take = '0;
      if (adv_valid && !blocked && !flush_pulse && !rst_pulse)
         take = (adv_count > adv_avail) ? adv_avail : adv_count;
   end

   ring_ptr_step #(.PTR_W(PTR_W)) u_step (
      .ptr_in   (hw_ptr),
      .step     (take),
      .ring_len (len_q),
      .ptr_out  (hw_nxt)
   );

   assign hw_offset = hw_ptr[PTR_W-1:0] & (len_q[PTR_W-1:0] - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else if (rst_pulse) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else if (flush_pulse) begin
         rptr_q <= wptr_q;
      end else if (IS_RX) begin
         if (take != '0) wptr_q <= hw_nxt;
         if (wr_rptr)    rptr_q <= reg_wdata[PTR_W:0];
      end else begin
         if (take != '0) rptr_q <= hw_nxt;
         if (wr_wptr)    wptr_q <= reg_wdata[PTR_W:0];
      end
   end

   always_comb begin
      clr = '0;
      if (wr_flag)
         clr = IS_RX ? reg_wdata[1:0] : {1'b0, ~reg_wdata[0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         ien_q  <= '0;
         en_q   <= 1'b0;
         stop_q <= 1'b0;
         len_q  <= LEN_RST;
         thre_q <= THRE_RST;
      end else begin
         if (rst_pulse) flag_q <= '0;
         else           flag_q <= (flag_q & ~clr) | (cond ? FLAG_MASK : 2'b00);
         if (wr_ien)  ien_q  <= reg_wdata[1:0] & FLAG_MASK;
         if (wr_en)   en_q   <= reg_wdata[0];
         if (wr_stop) stop_q <= reg_wdata[0];
         if (wr_len)  len_q  <= reg_wdata[PTR_W:0];
         if (wr_thre) thre_q <= reg_wdata[PTR_W:0];
      end
   end

   assign irq = |(flag_q & ien_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_FLAG:  reg_rdata = DW'(flag_q);
         ADR_IEN:   reg_rdata = DW'(ien_q);
         ADR_EN:    reg_rdata = DW'(en_q);
         ADR_STOP:  reg_rdata = DW'(stop_q);
         ADR_LEN:   reg_rdata = DW'(len_q);
         ADR_THRE:  reg_rdata = DW'(thre_q);
         ADR_WPTR:  reg_rdata = DW'(wptr_q);
         ADR_RPTR:  reg_rdata = DW'(rptr_q);
         ADR_VALID: reg_rdata = DW'(valid_cnt);
         ADR_LEFT:  reg_rdata = DW'(left_cnt);
         default:   reg_rdata = '0;
      endcase
   end

   // R5
   avail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> adv_avail == $past(adv_avail) - $past(take));

   // R6
   blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && blocked) |=> $stable(hw_ptr));

   // R7
   flush_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_pulse && !rst_pulse) |=> rptr_q == wptr_q);

   // R8
   warm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> (wptr_q == '0 && rptr_q == '0 && flag_q == '0));

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond && !rst_pulse) |=> flag_q[0]);
endmodule

// File: tb/ring_ptr_tracker_bench.sv
module ring_ptr_tracker_bench;
   localparam int PW = 5;
   localparam logic [7:0] A_FLAG = 8'h00, A_IEN = 8'h04, A_EN = 8'h08, A_WRST = 8'h0C,
                          A_STOP = 8'h10, A_FLUSH = 8'h14, A_LEN = 8'h24, A_THRE = 8'h28,
                          A_WPTR = 8'h2C, A_RPTR = 8'h30, A_VALID = 8'h3C, A_LEFT = 8'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        rwr   [2];
   logic [7:0]  raddr [2];
   logic [31:0] rwd   [2];
   logic [31:0] rrd   [2];
   logic        av    [2];
   logic [PW:0] ac    [2];
   logic [PW:0] aa    [2];
   logic [PW-1:0] ho  [2];
   logic        irq   [2];

   ring_ptr_tracker #(.PTR_W(PW), .IS_RX(1'b0), .DW(32)) u_ring_ptr_tracker (
      .clk(clk), .rst_n(rst_n), .reg_wr(rwr[0]), .reg_addr(raddr[0]), .reg_wdata(rwd[0]),
      .reg_rdata(rrd[0]), .adv_valid(av[0]), .adv_count(ac[0]), .adv_avail(aa[0]),
      .hw_offset(ho[0]), .irq(irq[0]));

   ring_ptr_tracker #(.PTR_W(PW), .IS_RX(1'b1), .DW(32)) u_ring_ptr_tracker_rx (
      .clk(clk), .rst_n(rst_n), .reg_wr(rwr[1]), .reg_addr(raddr[1]), .reg_wdata(rwd[1]),
      .reg_rdata(rrd[1]), .adv_valid(av[1]), .adv_count(ac[1]), .adv_avail(aa[1]),
      .hw_offset(ho[1]), .irq(irq[1]));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input int got, input int exp, input string what);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   task automatic wr_reg(input int ch, input logic [7:0] a, input int d);
      @(negedge clk);
      rwr[ch] = 1'b1; raddr[ch] = a; rwd[ch] = d;
      @(negedge clk);
      rwr[ch] = 1'b0;
   endtask

   task automatic rd_reg(input int ch, input logic [7:0] a, output int v);
      raddr[ch] = a;
      #1;
      v = int'(rrd[ch]);
   endtask

   task automatic hw_adv(input int ch, input int n);
      @(negedge clk);
      av[ch] = 1'b1; ac[ch] = n[PW:0];
      @(negedge clk);
      av[ch] = 1'b0;
   endtask

   function automatic int m_adv(int p, int n, int len);
      int off, wrap, s;
      off = p & (len - 1); wrap = (p >> PW) & 1; s = off + n;
      if (s >= len) return ((wrap ^ 1) << PW) | (s & (len - 1));
      return (wrap << PW) | s;
   endfunction

   function automatic int m_valid(int w, int r, int len);
      int wo, ro;
      wo = w & (len - 1); ro = r & (len - 1);
      if (((w >> PW) & 1) == ((r >> PW) & 1)) return wo - ro;
      return len - ro + wo;
   endfunction

   task automatic sweep(input int ch, input int len);
      int mw, mr, v, amt, req, avl, tk, thre, got, cond;
      wr_reg(ch, A_LEN, len);
      wr_reg(ch, A_WRST, 1);
      wr_reg(ch, A_EN, 1);
      wr_reg(ch, A_STOP, 0);
      wr_reg(ch, A_IEN, 3);
      mw = 0; mr = 0;
      for (int i = 0; i < 2 * len + 6; i++) begin
         thre = i % (len + 1);
         wr_reg(ch, A_THRE, thre);
         v = m_valid(mw, mr, len);
         if (ch == 0) begin
            amt = (i * 5 + 1) % (len - v + 1);
            mw = m_adv(mw, amt, len);
            wr_reg(ch, A_WPTR, mw);
         end else begin
            amt = (i * 3 + 2) % (v + 1);
            mr = m_adv(mr, amt, len);
            wr_reg(ch, A_RPTR, mr);
         end
         v = m_valid(mw, mr, len);
         avl = (ch == 0) ? v : len - v;
         chk(int'(aa[ch]), avl, "R4 adv_avail");
         req = (i * 7 + 3) % (len + 4);
         tk = (req > avl) ? avl : req;
         hw_adv(ch, req);
         if (ch == 0) mr = m_adv(mr, tk, len);
         else         mw = m_adv(mw, tk, len);
         v = m_valid(mw, mr, len);
         rd_reg(ch, A_WPTR, got);  chk(got, mw, "R2 R5 write pointer");
         rd_reg(ch, A_RPTR, got);  chk(got, mr, "R2 R5 read pointer");
         rd_reg(ch, A_VALID, got); chk(got, v, "R3 valid size");
         rd_reg(ch, A_LEFT, got);  chk(got, len - v, "R3 left size");
         chk(int'(ho[ch]), ((ch == 0) ? mr : mw) & (len - 1), "R4 hw_offset");
         cond = (ch == 0) ? int'((len - v) >= thre) : int'(v >= thre);
         wr_reg(ch, A_FLAG, (ch == 0) ? 0 : 3);
         rd_reg(ch, A_FLAG, got);
         chk(got, cond != 0 ? ((ch == 0) ? 1 : 3) : 0, "R9 R10 flag after clear");
         chk(int'(irq[ch]), cond, "R11 irq");
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int got;
      for (int c = 0; c < 2; c++) begin
         rwr[c] = 1'b0; raddr[c] = '0; rwd[c] = '0; av[c] = 1'b0; ac[c] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int c = 0; c < 2; c++) begin
         rd_reg(c, A_LEN, got);   chk(got, 32, "R1 R12 length reset");
         rd_reg(c, A_THRE, got);  chk(got, 63, "R1 R12 threshold reset");
         rd_reg(c, A_WPTR, got);  chk(got, 0, "R1 write pointer reset");
         rd_reg(c, A_RPTR, got);  chk(got, 0, "R1 read pointer reset");
         rd_reg(c, A_LEFT, got);  chk(got, 32, "R1 R3 left reset");
         rd_reg(c, A_FLAG, got);  chk(got, 0, "R1 flag reset");
         rd_reg(c, A_EN, got);    chk(got, 0, "R1 enable reset");
         rd_reg(c, 8'h18, got);   chk(got, 0, "R12 unmapped address");
         chk(int'(irq[c]), 0, "R1 irq reset");
      end

      // TX: blocking, ownership, flush, warm reset
      wr_reg(0, A_WPTR, 10);
      hw_adv(0, 4);
      rd_reg(0, A_RPTR, got); chk(got, 0, "R6 advance with enable clear");
      wr_reg(0, A_EN, 1);
      wr_reg(0, A_STOP, 1);
      hw_adv(0, 4);
      rd_reg(0, A_RPTR, got); chk(got, 0, "R6 advance with stop set");
      wr_reg(0, A_STOP, 0);
      hw_adv(0, 4);
      rd_reg(0, A_RPTR, got); chk(got, 4, "R6 advance when running");
      wr_reg(0, A_RPTR, 7);
      rd_reg(0, A_RPTR, got); chk(got, 4, "R4 software write to owned pointer");
      wr_reg(0, A_FLUSH, 1);
      rd_reg(0, A_RPTR, got); chk(got, 10, "R7 flush aligns read pointer");
      rd_reg(0, A_FLUSH, got); chk(got, 0, "R7 flush reads zero");
      wr_reg(0, A_THRE, 3);
      wr_reg(0, A_WRST, 1);
      rd_reg(0, A_WPTR, got); chk(got, 0, "R8 warm reset write pointer");
      rd_reg(0, A_RPTR, got); chk(got, 0, "R8 warm reset read pointer");
      rd_reg(0, A_THRE, got); chk(got, 3, "R8 threshold kept");
      rd_reg(0, A_EN, got);   chk(got, 1, "R8 enable kept");

      // TX flags
      @(negedge clk);
      rd_reg(0, A_FLAG, got); chk(got, 1, "R9 TX flag on left size");
      wr_reg(0, A_THRE, 40);
      wr_reg(0, A_FLAG, 1);
      rd_reg(0, A_FLAG, got); chk(got, 1, "R10 TX writing one keeps flag");
      wr_reg(0, A_FLAG, 0);
      rd_reg(0, A_FLAG, got); chk(got, 0, "R10 TX writing zero clears");
      wr_reg(0, A_IEN, 3);
      rd_reg(0, A_IEN, got);  chk(got, 1, "R11 TX enable bit 1 dropped");
      chk(int'(irq[0]), 0, "R11 irq low with flag clear");
      wr_reg(0, A_THRE, 3);
      @(negedge clk);
      chk(int'(irq[0]), 1, "R11 irq follows flag");

      // RX flags
      wr_reg(1, A_THRE, 0);
      @(negedge clk);
      rd_reg(1, A_FLAG, got); chk(got, 3, "R9 RX flags on valid size");
      wr_reg(1, A_THRE, 40);
      wr_reg(1, A_FLAG, 1);
      rd_reg(1, A_FLAG, got); chk(got, 2, "R10 RX clear bit 0 only");
      wr_reg(1, A_IEN, 2);
      chk(int'(irq[1]), 1, "R11 RX enable bit 1");
      wr_reg(1, A_IEN, 1);
      chk(int'(irq[1]), 0, "R11 RX enable bit 0 masks");
      wr_reg(1, A_FLAG, 2);
      rd_reg(1, A_FLAG, got); chk(got, 0, "R10 RX clear bit 1");

      // RX ownership and flush
      wr_reg(1, A_EN, 1);
      hw_adv(1, 5);
      rd_reg(1, A_WPTR, got); chk(got, 5, "R4 RX hardware moves write pointer");
      wr_reg(1, A_WPTR, 9);
      rd_reg(1, A_WPTR, got); chk(got, 5, "R4 RX software write ignored");
      wr_reg(1, A_FLUSH, 1);
      rd_reg(1, A_RPTR, got);  chk(got, 5, "R7 RX flush");
      rd_reg(1, A_VALID, got); chk(got, 0, "R7 RX empty after flush");

      for (int c = 0; c < 2; c++) begin
         sweep(c, 8);
         sweep(c, 16);
         sweep(c, 32);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule